// File: doc/BRIEF.md
# Egress Timestamp Queue With Register Readout

This block collects one record for every transmitted precision-time event message and holds it until software fetches it. A capture strobe from the egress frame parser delivers the record. It carries the domain number, the message type, the sequence ID, a 30-bit nanoseconds value and the low five bits of seconds. Records wait in a small first-in first-out queue, oldest first.

Software fetches records through a small register window. A "next" command moves the oldest queued record into a readout holder. Four 16-bit data words then show that record, packed into fixed fields with a valid flag. Software issues the command first, then reads the words. It stops when the valid flag reads 0. An interrupt line stays high while enabled records wait in the queue. It needs no acknowledge and drops by itself once the queue has been drained. A capture that finds the queue full is discarded and raises a sticky overflow flag.

Register map (3-bit address): 0 to 3 are data words 0 to 3 (read), 4 is the next command (write, bit 0), 5 is the interrupt enable (read/write, bit 0), and 6 is the status (read: bit 0 pending, bit 1 overflow; write: bit 1 clears overflow).

Top module: `egts_readout`

## Requirements
- R1: After reset the queue is empty, the four data words read 0, the status and the enable read 0, and `irq_o` is low.
- R2: Each cycle with `cap_vld` high appends one record, and records leave the queue in capture order. The queue holds `DEPTH` (default 4) records.
- R3: A write to address 4 with bit 0 set moves the oldest queued record into the readout holder and removes it from the queue. A write to address 4 with bit 0 clear changes nothing.
- R4: Data word 0 (address 0) packs the domain number in bits 7:0, the message type in bits 11:8 and seconds bits 4:2 in bits 14:12. Bit 15 is 1 when the holder contains a record.
- R5: Data word 1 (address 1) is the 16-bit sequence ID. Data word 2 (address 2) is nanoseconds bits 15:0.
- R6: Data word 3 (address 3) holds nanoseconds bits 29:16 in bits 13:0 and seconds bits 1:0 in bits 15:14.
- R7: A next command while the queue is empty makes all four data words read 0, so bit 15 of word 0 is 0.
- R8: A capture into a full queue that is not popped in the same cycle is dropped and sets the overflow flag (status bit 1). The flag stays set until a status write with bit 1 set clears it.
- R9: A capture and a next command in the same cycle both take effect. With a full queue, the capture is kept. With an empty queue, the holder becomes invalid and the capture is queued.
- R10: `irq_o` is high exactly when the enable bit (address 5, bit 0) is 1 and the queue holds at least one record. Status bit 0 shows whether the queue holds a record, whatever the enable.
- R11: `reg_rdata` is loaded on the clock edge that samples `reg_rd` and holds its value while `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_vld | input | 1 | Capture strobe for one egress event record |
| cap_domain | input | 8 | Domain number of the captured message |
| cap_msgtype | input | 4 | Message type of the captured message |
| cap_seqid | input | 16 | Sequence ID of the captured message |
| cap_nsec | input | 30 | Nanoseconds of the egress time |
| cap_sec | input | 5 | Low five bits of seconds of the egress time |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Level interrupt: enabled records pending |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume that all inputs are stable around the clock edge and that the capture fields are meaningful only when `cap_vld` is high. The bench drives every input just after a rising edge and never raises read and write together. Its random mix of captures, next commands, simultaneous capture-and-next and interrupt-enable changes reaches the full and empty boundaries, which keeps the stimulus inside those assumptions while covering them.

// File: rtl/egts_pkg.sv
package egts_pkg;
  localparam int DOM_W  = 8;
  localparam int TYP_W  = 4;
  localparam int SEQ_W  = 16;
  localparam int NS_W   = 30;
  localparam int SEC_W  = 5;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 3;

  typedef struct packed {
    logic [DOM_W-1:0] domain;
    logic [TYP_W-1:0] mtype;
    logic [SEQ_W-1:0] seqid;
    logic [NS_W-1:0]  nsec;
    logic [SEC_W-1:0] sec;
  } ts_rec_t;

  localparam logic [ADDR_W-1:0] RA_W0   = 3'd0;
  localparam logic [ADDR_W-1:0] RA_W1   = 3'd1;
  localparam logic [ADDR_W-1:0] RA_W2   = 3'd2;
  localparam logic [ADDR_W-1:0] RA_W3   = 3'd3;
  localparam logic [ADDR_W-1:0] RA_NEXT = 3'd4;
  localparam logic [ADDR_W-1:0] RA_IEN  = 3'd5;
  localparam logic [ADDR_W-1:0] RA_STAT = 3'd6;
endpackage

// File: rtl/egts_fifo.sv
module egts_fifo
  import egts_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    push,
  input  logic    pop,
  input  ts_rec_t din,
  output ts_rec_t head,
  output logic    empty,
  output logic    full,
  output logic    push_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  ts_rec_t        mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic           do_push, do_pop;

  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));
  assign do_pop    = pop && !empty;
  assign do_push   = push && (!full || do_pop);
  assign push_drop = push && !do_push;
  assign head      = mem[rp];

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (!do_push && do_pop) cnt <= cnt - CW'(1);
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop |=> full);
  a_r9_full_swap_keeps_full: assert property (@(posedge clk) disable iff (rst)
    full && push && pop |=> full);
endmodule

// File: rtl/egts_window.sv
module egts_window
  import egts_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              next_cmd,
  input  logic              fifo_empty,
  input  ts_rec_t           head,
  output logic [WORD_W-1:0] w0,
  output logic [WORD_W-1:0] w1,
  output logic [WORD_W-1:0] w2,
  output logic [WORD_W-1:0] w3
);
  logic    vld;
  ts_rec_t rec;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      rec <= '0;
    end else if (next_cmd) begin
      vld <= !fifo_empty;
      rec <= fifo_empty ? '0 : head;
    end
  end

  assign w0 = {vld, rec.sec[4:2], rec.mtype, rec.domain};
  assign w1 = rec.seqid;
  assign w2 = rec.nsec[15:0];
  assign w3 = {rec.sec[1:0], rec.nsec[29:16]};

  a_r7_empty_next_clears: assert property (@(posedge clk) disable iff (rst)
    next_cmd && fifo_empty |=> (w0 == '0) && (w3 == '0));
  a_r3_next_loads_valid: assert property (@(posedge clk) disable iff (rst)
    next_cmd && !fifo_empty |=> w0[15]);
  a_r3_hold_without_cmd: assert property (@(posedge clk) disable iff (rst)
    !next_cmd |=> $stable(w0) && $stable(w1));
endmodule

// File: rtl/egts_irq.sv
module egts_irq (
  input  logic clk,
  input  logic rst,
  input  logic ien_wr,
  input  logic ien_val,
  input  logic ovf_clr,
  input  logic drop,
  input  logic pending,
  output logic ien,
  output logic ovf,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= 1'b0;
      ovf <= 1'b0;
    end else begin
      if (ien_wr) ien <= ien_val;
      if (drop)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  assign irq = ien && pending;

  a_r10_quiet_when_empty: assert property (@(posedge clk) disable iff (rst)
    !pending |-> !irq);
  a_r8_drop_sets_flag: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf && !ovf_clr |=> ovf);
endmodule

// File: rtl/egts_readout.sv
module egts_readout
  import egts_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cap_vld,
  input  logic [7:0]  cap_domain,
  input  logic [3:0]  cap_msgtype,
  input  logic [15:0] cap_seqid,
  input  logic [29:0] cap_nsec,
  input  logic [4:0]  cap_sec,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq_o
);
  ts_rec_t           cap_rec, head;
  logic              empty, full, drop;
  logic              next_cmd, ien_wr, ovf_clr, ien, ovf;
  logic [WORD_W-1:0] w0, w1, w2, w3;

  assign cap_rec  = '{domain: cap_domain, mtype: cap_msgtype, seqid: cap_seqid,
                      nsec: cap_nsec, sec: cap_sec};
  assign next_cmd = reg_wr && (reg_addr == RA_NEXT) && reg_wdata[0];
  assign ien_wr   = reg_wr && (reg_addr == RA_IEN);
  assign ovf_clr  = reg_wr && (reg_addr == RA_STAT) && reg_wdata[1];

  egts_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(cap_vld), .pop(next_cmd), .din(cap_rec),
    .head(head), .empty(empty), .full(full), .push_drop(drop)
  );

  egts_window u_win (
    .clk(clk), .rst(rst), .next_cmd(next_cmd), .fifo_empty(empty), .head(head),
    .w0(w0), .w1(w1), .w2(w2), .w3(w3)
  );

  egts_irq u_irq (
    .clk(clk), .rst(rst), .ien_wr(ien_wr), .ien_val(reg_wdata[0]),
    .ovf_clr(ovf_clr), .drop(drop), .pending(!empty),
    .ien(ien), .ovf(ovf), .irq(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_W0:   reg_rdata <= w0;
        RA_W1:   reg_rdata <= w1;
        RA_W2:   reg_rdata <= w2;
        RA_W3:   reg_rdata <= w3;
        RA_IEN:  reg_rdata <= {15'd0, ien};
        RA_STAT: reg_rdata <= {14'd0, ovf, !empty};
        default: reg_rdata <= '0;
      endcase
    end
  end

  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/sim_egts_readout.sv
module sim_egts_readout;
  localparam int DEPTH = 4;

  typedef struct packed {
    logic [7:0]  dom;
    logic [3:0]  typ;
    logic [15:0] seq;
    logic [29:0] ns;
    logic [4:0]  s;
  } brec_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_vld = 1'b0;
  logic [7:0]  cap_domain = '0;
  logic [3:0]  cap_msgtype = '0;
  logic [15:0] cap_seqid = '0;
  logic [29:0] cap_nsec = '0;
  logic [4:0]  cap_sec = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  brec_t mq[$];
  bit    wv = 1'b0;
  brec_t wrec = '0;
  bit    m_ien = 1'b0;
  bit    m_ovf = 1'b0;

  always #5 clk = ~clk;

  egts_readout #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cap_vld(cap_vld), .cap_domain(cap_domain),
    .cap_msgtype(cap_msgtype), .cap_seqid(cap_seqid), .cap_nsec(cap_nsec),
    .cap_sec(cap_sec), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic logic [15:0] exp_word(int idx);
    case (idx)
      0: return {wv, wrec.s[4:2], wrec.typ, wrec.dom};
      1: return wrec.seq;
      2: return wrec.ns[15:0];
      default: return {wrec.s[1:0], wrec.ns[29:16]};
    endcase
  endfunction

  function automatic brec_t rnd_rec();
    brec_t r;
    r.dom = 8'($urandom);
    r.typ = 4'($urandom);
    r.seq = 16'($urandom);
    r.ns  = 30'($urandom);
    r.s   = 5'($urandom);
    return r;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cap_vld = 1'b0;
    reg_wr  = 1'b0;
    reg_rd  = 1'b0;
  endtask

  // one cycle carrying an optional capture and an optional next command
  task automatic op(bit cap, bit nxt, brec_t r);
    bit popped;
    cap_vld = cap;
    {cap_domain, cap_msgtype, cap_seqid, cap_nsec, cap_sec} = r;
    if (nxt) begin
      reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0001;
    end
    tick();
    popped = nxt && (mq.size() > 0);
    if (nxt) begin
      if (mq.size() > 0) begin wv = 1'b1; wrec = mq.pop_front(); end
      else begin wv = 1'b0; wrec = '0; end
    end
    if (cap) begin
      if (mq.size() < DEPTH) mq.push_back(r);
      else m_ovf = 1'b1;
    end
    if (popped) ; // order already handled
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    d = reg_rdata;
  endtask

  task automatic check_words(string req);
    logic [15:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), d);
      chk(req, d, exp_word(i));
    end
  endtask

  task automatic check_stat(string req);
    logic [15:0] d;
    rd(3'd6, d);
    chk(req, d, {14'd0, m_ovf, mq.size() > 0});
  endtask

  task automatic check_irq(string req);
    chk(req, {15'd0, irq_o}, {15'd0, m_ien && (mq.size() > 0)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    brec_t a, b;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    check_words("R1");
    check_stat("R1");
    rd(3'd5, d); chk("R1 ien", d, 16'h0000);
    check_irq("R1");

    // R7 next on empty queue
    op(1'b0, 1'b1, '0);
    check_words("R7");

    // R10 enable, one record pending
    wr(3'd5, 16'h0001); m_ien = 1'b1;
    rd(3'd5, d); chk("R10 ien", d, 16'h0001);
    a = '{dom: 8'hA5, typ: 4'h3, seq: 16'hBEEF, ns: 30'h2345_6789, s: 5'b10110};
    op(1'b1, 1'b0, a);
    check_irq("R10 pending");
    check_stat("R10 stat");

    // R11 data holds with no read strobe
    rd(3'd6, d);
    tick();
    chk("R11 hold", reg_rdata, d);

    // R3 next with bit0 clear does nothing
    wr(3'd4, 16'hFFFE);
    check_words("R3 no-op");
    check_irq("R3 no-op irq");

    // R3 R4 R5 R6 next loads record
    op(1'b0, 1'b1, '0);
    chk("R4 word0", exp_word(0), {1'b1, 3'b101, 4'h3, 8'hA5});
    chk("R6 word3", exp_word(3), {2'b10, 14'h2345 >> 0 & 14'h3FFF});
    check_words("R4 R5 R6");
    check_irq("R10 drained");

    // R2 R8 fill, overflow, drain in order
    for (int i = 0; i < DEPTH + 1; i++) op(1'b1, 1'b0, rnd_rec());
    check_stat("R8 overflow set");
    check_irq("R10 full");
    for (int i = 0; i < DEPTH; i++) begin
      op(1'b0, 1'b1, '0);
      check_words("R2 order");
    end
    check_stat("R8 sticky");
    op(1'b0, 1'b1, '0);
    check_words("R7 after drain");
    wr(3'd6, 16'h0002); m_ovf = 1'b0;
    check_stat("R8 cleared");

    // R9 full queue, capture and next together
    for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, rnd_rec());
    b = rnd_rec();
    op(1'b1, 1'b1, b);
    check_words("R9 full");
    check_stat("R9 no overflow");
    for (int i = 0; i < DEPTH; i++) begin
      op(1'b0, 1'b1, '0);
      check_words("R9 order");
    end
    // R9 empty queue, capture and next together
    op(1'b1, 1'b1, rnd_rec());
    check_words("R9 empty");
    check_irq("R9 queued");
    op(1'b0, 1'b1, '0);
    check_words("R9 drained");

    // R10 pending but disabled
    op(1'b1, 1'b0, rnd_rec());
    wr(3'd5, 16'h0000); m_ien = 1'b0;
    check_irq("R10 disabled");
    check_stat("R10 stat disabled");
    op(1'b0, 1'b1, '0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k < 4)      op(1'b1, 1'b0, rnd_rec());
      else if (k < 7) op(1'b0, 1'b1, '0);
      else if (k < 8) op(1'b1, 1'b1, rnd_rec());
      else if (k < 9) begin
        m_ien = 1'($urandom);
        wr(3'd5, {15'd0, m_ien});
      end else begin
        wr(3'd6, 16'h0002); m_ovf = 1'b0;
      end
      check_irq("R10 random");
      if (i % 5 == 0) begin
        check_words("R2 R3 random");
        check_stat("R8 random");
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule